// File: doc/BRIEF.md
# Virtual Function Routing ID Mapper

This block converts between a virtual function number and its 16-bit routing ID for one physical function of a device that shares itself among several system images. It is fed with the routing ID of its physical function, the first-VF offset, the VF stride, the number of VFs currently set up and the VF enable bit. These usually come straight from the function's configuration registers, which live elsewhere.

The forward path is purely combinational. It gives the routing ID of a requested VF together with a flag that says whether that VF currently exists. The same routing ID is also split into bus, device and function fields. When alternative routing-ID interpretation is on, it is split into bus and an 8-bit function field instead.

The reverse path takes an incoming routing ID and one cycle later reports whether it belongs to an enabled VF of this physical function, and which one. It finds the index with a division by the stride, so no table of VFs is stored. All routing-ID arithmetic wraps at 2^16, so a VF set may cross the top of the ID space and carry onto higher bus numbers.

Top module: `vf_rid_mapper`

## Requirements
- R1: `fwd_rid` equals (`cfg_pf_rid` + `cfg_first_ofs` + (`fwd_vf` − 1) × `cfg_stride`) modulo 2^16, with every carry dropped. VF 1 sits at PF ID + offset, and VFs may land on a higher bus number than the PF.
- R2: `fwd_ok` is 1 only when `cfg_vf_en` is 1 and 1 ≤ `fwd_vf` ≤ `cfg_num_vfs`. `fwd_rid` is still computed when `fwd_ok` is 0.
- R3: Let D = (`rev_rid` − `cfg_pf_rid` − `cfg_first_ofs`) mod 2^16. With a nonzero stride, a request is a hit when D is an exact multiple of the stride and D/stride < `cfg_num_vfs`. In the cycle after `rev_req`, `rev_valid` is 1, `rev_hit` is 1 and `rev_vf` = D/stride + 1.
- R4: A request whose D is not a multiple of the stride, whose index would exceed `cfg_num_vfs`, or that arrives while `cfg_num_vfs` is 0, gives `rev_valid` = 1, `rev_hit` = 0 and `rev_vf` = 0.
- R5: While `cfg_vf_en` is 0, no request gives a hit, and `rev_vf` reads 0.
- R6: With a stride of 0, only D = 0 matches, and it reports VF 1 when `cfg_num_vfs` ≥ 1.
- R7: Forward and reverse results stay correct when the VF set wraps from FFFFh to 0000h.
- R8: With `cfg_ari` = 0, `fwd_bus` = `fwd_rid`[15:8], `fwd_dev` = `fwd_rid`[7:3] and `fwd_fn` = `fwd_rid`[2:0] zero-extended to 8 bits.
- R9: With `cfg_ari` = 1, `fwd_bus` = `fwd_rid`[15:8], `fwd_fn` = `fwd_rid`[7:0] and `fwd_dev` = 0.
- R10: After reset, `rev_valid`, `rev_hit` and `rev_vf` are 0.
- R11: A cycle without `rev_req` gives `rev_valid` = 0 and `rev_hit` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pf_rid | input | 16 | Routing ID of the physical function |
| cfg_first_ofs | input | 16 | Offset from the PF ID to VF 1 |
| cfg_stride | input | 16 | Routing-ID distance between consecutive VFs |
| cfg_num_vfs | input | 16 | Number of VFs currently set up |
| cfg_vf_en | input | 1 | VF enable |
| cfg_ari | input | 1 | Split IDs as bus/function instead of bus/device/function |
| fwd_vf | input | 16 | VF number to translate (1-based) |
| fwd_rid | output | 16 | Routing ID of `fwd_vf` |
| fwd_ok | output | 1 | `fwd_vf` names an existing, enabled VF |
| fwd_bus | output | 8 | Bus field of `fwd_rid` |
| fwd_dev | output | 5 | Device field of `fwd_rid` (0 in ARI split) |
| fwd_fn | output | 8 | Function field of `fwd_rid` |
| rev_req | input | 1 | Reverse lookup request |
| rev_rid | input | 16 | Routing ID to look up |
| rev_valid | output | 1 | A lookup result is presented this cycle |
| rev_hit | output | 1 | The looked-up ID belongs to an enabled VF |
| rev_vf | output | 16 | Matched VF number, 0 on a miss |

## Verification
The bench builds the block with its default 16-bit routing ID, 16-bit VF count, an 8-bit bus field and a 3-bit legacy function field. These widths make the full modulo-2^16 behaviour reachable. This covers VF sets that wrap past FFFFh, a request below the PF's ID whose negative distance turns into a huge quotient, and the last of 80 VFs landing on the next bus. Both field splits are checked on one ID whose upper function bits are nonzero, so a swapped split shows up at once.

// File: rtl/vfrid_pkg.sv
`timescale 1ns/1ps
package vfrid_pkg;
  localparam int RID_W    = 16;
  localparam int CNT_W    = 16;
  localparam int BUS_W    = 8;
  localparam int LEG_FN_W = 3;
  localparam int FN_W     = RID_W - BUS_W;
  localparam int DEV_W    = FN_W - LEG_FN_W;

  typedef enum logic {
    SPLIT_BDF    = 1'b0,
    SPLIT_BUS_FN = 1'b1
  } split_mode_e;
endpackage

// File: rtl/vfrid_fwd_calc.sv
`timescale 1ns/1ps
module vfrid_fwd_calc #(
  parameter int RID_W = vfrid_pkg::RID_W,
  parameter int CNT_W = vfrid_pkg::CNT_W
) (
  input  logic [RID_W-1:0] pf_rid,
  input  logic [RID_W-1:0] first_ofs,
  input  logic [RID_W-1:0] stride,
  input  logic [CNT_W-1:0] num_vfs,
  input  logic             vf_en,
  input  logic [CNT_W-1:0] vf_n,
  output logic [RID_W-1:0] rid,
  output logic             ok
);
  logic [RID_W-1:0] idx0;
  logic [RID_W-1:0] span;

  always_comb begin
    idx0 = RID_W'(vf_n) - RID_W'(1);
    span = idx0 * stride;
    rid  = pf_rid + first_ofs + span;
    ok   = vf_en && (vf_n != '0) && (vf_n <= num_vfs);
  end
endmodule

// File: rtl/vfrid_divider.sv
`timescale 1ns/1ps
module vfrid_divider #(
  parameter int W = vfrid_pkg::RID_W
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] part [W+1];

  assign part[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_step
    localparam int B = W - 1 - i;
    logic [W:0] trial;
    logic [W:0] diff;
    assign trial     = {part[i], dividend[B]};
    assign diff      = trial - {1'b0, divisor};
    assign quo[B]    = (trial >= {1'b0, divisor});
    assign part[i+1] = quo[B] ? diff[W-1:0] : trial[W-1:0];
  end

  assign rem = part[W];
endmodule

// File: rtl/vfrid_rev_lookup.sv
`timescale 1ns/1ps
module vfrid_rev_lookup #(
  parameter int RID_W = vfrid_pkg::RID_W,
  parameter int CNT_W = vfrid_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arst_n,
  input  logic [RID_W-1:0] pf_rid,
  input  logic [RID_W-1:0] first_ofs,
  input  logic [RID_W-1:0] stride,
  input  logic [CNT_W-1:0] num_vfs,
  input  logic             vf_en,
  input  logic             req,
  input  logic [RID_W-1:0] rid,
  output logic             valid,
  output logic             hit,
  output logic [CNT_W-1:0] vf
);
  logic [RID_W-1:0] delta;
  logic [RID_W-1:0] quo;
  logic [RID_W-1:0] rem;
  logic             match;
  logic [CNT_W-1:0] vf_match;
  logic             valid_d;
  logic             hit_d;
  logic [CNT_W-1:0] vf_d;
  logic             vf_load;

  assign delta = rid - pf_rid - first_ofs;

  vfrid_divider #(.W(RID_W)) u_div (
    .dividend (delta),
    .divisor  (stride),
    .quo      (quo),
    .rem      (rem)
  );

  always_comb begin
    if (stride == '0) begin
      match    = (delta == '0) && (num_vfs != '0);
      vf_match = CNT_W'(1);
    end else begin
      match    = (rem == '0) && (CNT_W'(quo) < num_vfs) && (quo < RID_W'(num_vfs));
      vf_match = CNT_W'(quo) + CNT_W'(1);
    end
    valid_d = req;
    hit_d   = req && vf_en && match;
    vf_d    = hit_d ? vf_match : '0;
    vf_load = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      hit   <= 1'b0;
      vf    <= '0;
    end else begin
      valid <= valid_d;
      hit   <= hit_d;
      if (vf_load) begin
        vf <= vf_d;
      end
    end
  end

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!arst_n)
    (stride != '0) |-> ((2*RID_W)'(quo) * (2*RID_W)'(stride) + (2*RID_W)'(rem) == (2*RID_W)'(delta))); // R3

  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    hit |-> (vf != '0) && (vf <= $past(num_vfs)) && valid); // R3

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(vf_en) |-> !hit); // R5

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(req) |-> (!valid && !hit)); // R11

  AST_ZERO_STRIDE_ONE: assert property (@(posedge clk) disable iff (!arst_n)
    (hit && ($past(stride) == '0)) |-> (vf == CNT_W'(1))); // R6
endmodule

// File: rtl/vfrid_field_split.sv
`timescale 1ns/1ps
module vfrid_field_split
  import vfrid_pkg::*;
#(
  parameter int RID_W    = vfrid_pkg::RID_W,
  parameter int BUS_W    = vfrid_pkg::BUS_W,
  parameter int LEG_FN_W = vfrid_pkg::LEG_FN_W,
  localparam int FN_W    = RID_W - BUS_W,
  localparam int DEV_W   = FN_W - LEG_FN_W
) (
  input  split_mode_e      mode,
  input  logic [RID_W-1:0] rid,
  output logic [BUS_W-1:0] bus,
  output logic [DEV_W-1:0] dev,
  output logic [FN_W-1:0]  fn
);
  always_comb begin
    bus = rid[RID_W-1 -: BUS_W];
    case (mode)
      SPLIT_BUS_FN: begin
        dev = '0;
        fn  = rid[FN_W-1:0];
      end
      default: begin
        dev = rid[FN_W-1:LEG_FN_W];
        fn  = FN_W'(rid[LEG_FN_W-1:0]);
      end
    endcase
  end
endmodule

// File: rtl/vf_rid_mapper.sv
`timescale 1ns/1ps
module vf_rid_mapper
  import vfrid_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RID_W-1:0]    cfg_pf_rid,
  input  logic [RID_W-1:0]    cfg_first_ofs,
  input  logic [RID_W-1:0]    cfg_stride,
  input  logic [CNT_W-1:0]    cfg_num_vfs,
  input  logic                cfg_vf_en,
  input  logic                cfg_ari,
  input  logic [CNT_W-1:0]    fwd_vf,
  output logic [RID_W-1:0]    fwd_rid,
  output logic                fwd_ok,
  output logic [BUS_W-1:0]    fwd_bus,
  output logic [DEV_W-1:0]    fwd_dev,
  output logic [FN_W-1:0]     fwd_fn,
  input  logic                rev_req,
  input  logic [RID_W-1:0]    rev_rid,
  output logic                rev_valid,
  output logic                rev_hit,
  output logic [CNT_W-1:0]    rev_vf
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  split_mode_e            split_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  assign split_mode = cfg_ari ? SPLIT_BUS_FN : SPLIT_BDF;

  vfrid_fwd_calc #(.RID_W(RID_W), .CNT_W(CNT_W)) u_fwd (
    .pf_rid    (cfg_pf_rid),
    .first_ofs (cfg_first_ofs),
    .stride    (cfg_stride),
    .num_vfs   (cfg_num_vfs),
    .vf_en     (cfg_vf_en),
    .vf_n      (fwd_vf),
    .rid       (fwd_rid),
    .ok        (fwd_ok)
  );

  vfrid_field_split #(.RID_W(RID_W), .BUS_W(BUS_W), .LEG_FN_W(LEG_FN_W)) u_split (
    .mode (split_mode),
    .rid  (fwd_rid),
    .bus  (fwd_bus),
    .dev  (fwd_dev),
    .fn   (fwd_fn)
  );

  vfrid_rev_lookup #(.RID_W(RID_W), .CNT_W(CNT_W)) u_rev (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .arst_n    (rst_n),
    .pf_rid    (cfg_pf_rid),
    .first_ofs (cfg_first_ofs),
    .stride    (cfg_stride),
    .num_vfs   (cfg_num_vfs),
    .vf_en     (cfg_vf_en),
    .req       (rev_req),
    .rid       (rev_rid),
    .valid     (rev_valid),
    .hit       (rev_hit),
    .vf        (rev_vf)
  );

  AST_FWD_FIRST_VF: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_vf == CNT_W'(1)) |-> (fwd_rid == RID_W'(cfg_pf_rid + cfg_first_ofs))); // R1

  AST_SPLIT_BDF_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ari |-> ({fwd_bus, fwd_dev, fwd_fn[LEG_FN_W-1:0]} == fwd_rid) && (fwd_fn[FN_W-1:LEG_FN_W] == '0)); // R8

  AST_SPLIT_ARI_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ari |-> ({fwd_bus, fwd_fn} == fwd_rid) && (fwd_dev == '0)); // R9
endmodule

// File: tb/vf_rid_mapper_test.sv
`timescale 1ns/1ps
module vf_rid_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_pf_rid, cfg_first_ofs, cfg_stride, cfg_num_vfs;
  logic        cfg_vf_en, cfg_ari;
  logic [15:0] fwd_vf, fwd_rid;
  logic        fwd_ok;
  logic [7:0]  fwd_bus;
  logic [4:0]  fwd_dev;
  logic [7:0]  fwd_fn;
  logic        rev_req;
  logic [15:0] rev_rid;
  logic        rev_valid, rev_hit;
  logic [15:0] rev_vf;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vf_rid_mapper uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_pf_rid(cfg_pf_rid), .cfg_first_ofs(cfg_first_ofs), .cfg_stride(cfg_stride),
    .cfg_num_vfs(cfg_num_vfs), .cfg_vf_en(cfg_vf_en), .cfg_ari(cfg_ari),
    .fwd_vf(fwd_vf), .fwd_rid(fwd_rid), .fwd_ok(fwd_ok),
    .fwd_bus(fwd_bus), .fwd_dev(fwd_dev), .fwd_fn(fwd_fn),
    .rev_req(rev_req), .rev_rid(rev_rid),
    .rev_valid(rev_valid), .rev_hit(rev_hit), .rev_vf(rev_vf)
  );

  typedef struct packed {
    logic [15:0] pf, ofs, stride, num;
    logic        en;
    logic [15:0] rid;
    logic        hit;
    logic [15:0] vf;
    logic [15:0] fn;
    logic [15:0] frid;
    logic        fok;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b1, 16'h0206, 1'b1, 16'h0002, 16'h0003, 16'h020A, 1'b1, 8'd3}, // R3 R1
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b1, 16'h0207, 1'b0, 16'h0000, 16'h0001, 16'h0202, 1'b1, 8'd4}, // R4 R1
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b1, 16'h033E, 1'b1, 16'h0050, 16'h0050, 16'h033E, 1'b1, 8'd3}, // R3 R1 next bus
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b1, 16'h0342, 1'b0, 16'h0000, 16'h0051, 16'h0342, 1'b0, 8'd4}, // R4 R2
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b0, 16'h0202, 1'b0, 16'h0000, 16'h0001, 16'h0202, 1'b0, 8'd5}, // R5 R2
    '{16'h0100, 16'h0001, 16'h0000, 16'h0003, 1'b1, 16'h0101, 1'b1, 16'h0001, 16'h0002, 16'h0101, 1'b1, 8'd6}, // R6
    '{16'h0100, 16'h0001, 16'h0000, 16'h0003, 1'b1, 16'h0102, 1'b0, 16'h0000, 16'h0000, 16'h0101, 1'b0, 8'd6}, // R6 R2
    '{16'hFFF0, 16'h0008, 16'h0004, 16'h000A, 1'b1, 16'h0004, 1'b1, 16'h0004, 16'h0003, 16'h0000, 1'b1, 8'd7}, // R7
    '{16'hFFF0, 16'h0008, 16'h0004, 16'h000A, 1'b1, 16'hFFF4, 1'b0, 16'h0000, 16'h000A, 16'h001C, 1'b1, 8'd7}, // R7
    '{16'h0200, 16'h0002, 16'h0004, 16'h0050, 1'b1, 16'h01FE, 1'b0, 16'h0000, 16'h0000, 16'h01FE, 1'b0, 8'd4}, // R4 R2
    '{16'h0200, 16'h0002, 16'h0004, 16'h0000, 1'b1, 16'h0202, 1'b0, 16'h0000, 16'h0001, 16'h0202, 1'b0, 8'd4}, // R4 R2
    '{16'h0800, 16'h0100, 16'h0003, 16'h0005, 1'b1, 16'h0906, 1'b1, 16'h0003, 16'h0005, 16'h090C, 1'b1, 8'd3}  // R3 R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_pf_rid = 16'h0200; cfg_first_ofs = 16'h0002; cfg_stride = 16'h0004;
    cfg_num_vfs = 16'h0050; cfg_vf_en = 1'b1; cfg_ari = 1'b0;
    fwd_vf = 16'h0001; rev_req = 1'b0; rev_rid = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: outputs cleared after reset
    check("R10 valid", 32'(rev_valid), 32'd0);
    check("R10 hit",   32'(rev_hit),   32'd0);
    check("R10 vf",    32'(rev_vf),    32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cfg_pf_rid = VECS[i].pf;  cfg_first_ofs = VECS[i].ofs;
      cfg_stride = VECS[i].stride; cfg_num_vfs = VECS[i].num;
      cfg_vf_en = VECS[i].en;
      fwd_vf = VECS[i].fn;
      rev_req = 1'b1; rev_rid = VECS[i].rid;
      #1;
      check($sformatf("R1 fwd_rid vec%0d", i), 32'(fwd_rid), 32'(VECS[i].frid));
      check($sformatf("R2 fwd_ok vec%0d", i),  32'(fwd_ok),  32'(VECS[i].fok));
      @(negedge clk);
      check($sformatf("R%0d valid vec%0d", VECS[i].req, i), 32'(rev_valid), 32'd1);
      check($sformatf("R%0d hit vec%0d", VECS[i].req, i),   32'(rev_hit),   32'(VECS[i].hit));
      check($sformatf("R%0d vf vec%0d", VECS[i].req, i),    32'(rev_vf),    32'(VECS[i].vf));
    end

    // R11: matching ID without a request gives no result
    @(negedge clk);
    cfg_pf_rid = 16'h0200; cfg_first_ofs = 16'h0002; cfg_stride = 16'h0004;
    cfg_num_vfs = 16'h0050; cfg_vf_en = 1'b1;
    rev_req = 1'b0; rev_rid = 16'h0206;
    @(negedge clk);
    check("R11 valid", 32'(rev_valid), 32'd0);
    check("R11 hit",   32'(rev_hit),   32'd0);

    // R8 / R9: field split of ID 12A5h
    cfg_pf_rid = 16'h12A5; cfg_first_ofs = 16'h0000; cfg_stride = 16'h0000;
    cfg_num_vfs = 16'h0001; fwd_vf = 16'h0001; cfg_ari = 1'b0;
    #1;
    check("R8 bus", 32'(fwd_bus), 32'h12);
    check("R8 dev", 32'(fwd_dev), 32'h14);
    check("R8 fn",  32'(fwd_fn),  32'h05);
    cfg_ari = 1'b1;
    #1;
    check("R9 bus", 32'(fwd_bus), 32'h12);
    check("R9 dev", 32'(fwd_dev), 32'h00);
    check("R9 fn",  32'(fwd_fn),  32'hA5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule